// File: doc/BRIEF.md
# Matrix Key Change Reporter

This block sits between a keypad matrix scanner and whatever consumes key events. Each time the scanner has a fresh picture of which keys are down, it hands over up to eight slots, each a valid bit with a row and a column. The block turns every slot into a scan code. It checks the picture for the phantom keys that a diode-less matrix produces. It then compares the picture with the key set it last accepted and sends out the difference as a stream of events.

Events leave one at a time on a valid/ready handshake. Each event carries a code and a press flag. Release events for keys that disappeared come first, then a press event for every key in the new picture. A one-cycle sync pulse closes each accepted picture. An empty picture, which means the keypad has gone idle, releases every held key and clears the stored count.

An optional function-key mode remaps the whole keypad while one designated key is held. In that mode the designated key is swallowed and every other code moves up by the number of matrix positions. The block takes a new picture only while it is idle.

Top module: `key_change_reporter`

## Requirements
- R1: After reset, snap_ready is 1, ev_valid and ev_sync are 0 and held_count is 0.
- R2: The scan code of a slot is its row shifted left by the column field width (3 bits by default) ORed with its column, zero-extended to ev_code; only slots whose snap_mask bit is 1 count as keys.
- R3: In an accepted picture, every stored key whose code is absent from the new picture produces one event with ev_press = 0.
- R4: Every key of an accepted picture produces one event with ev_press = 1, whether or not it was already held.
- R5: All release events of a picture come before any of its press events. Within each group, events follow ascending slot index, using the stored slots for releases and the new slots for presses.
- R6: With ghost_en = 1 and at least 3 counted keys, a picture is ghosted when some pair of keys shares a row and some pair shares a column. A ghosted picture is dropped: no event, no sync, and held_count and the stored set are unchanged.
- R7: The ghost check is skipped when ghost_en = 0 or fewer than 3 keys are counted, and when no pair shares a column.
- R8: With fn_en = 1 and a key whose scan code equals FN_CODE (default 120, row 15 column 0) in the picture, that key is neither reported nor counted, and every other key's code is its scan code plus ROWS*COLS (128). With fn_en = 0 that key is an ordinary key.
- R9: A picture with no keys releases every stored key and leaves held_count at 0.
- R10: While ev_valid is 1 and ev_ready is 0, ev_valid, ev_code and ev_press hold their values. Each handshake transfers exactly one event.
- R11: Every accepted picture, including one with no events to send, ends with ev_sync high for exactly one cycle after its last event.
- R12: snap_ready is 1 only while the block is idle. It stays 0 from the acceptance of a picture through its sync cycle, so no event is offered while snap_ready is 1.
- R13: After the sync cycle, held_count equals the number of keys counted in the accepted picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ghost_en | input | 1 | Enables the ghost check |
| fn_en | input | 1 | Enables function-key remapping |
| snap_valid | input | 1 | A picture is offered |
| snap_ready | output | 1 | Block is idle and takes a picture |
| snap_mask | input | SLOTS (8) | Per-slot key-present bit |
| snap_rows | input | SLOTS*ROW_W (32) | Row of each slot, slot 0 in the low bits |
| snap_cols | input | SLOTS*COL_W (24) | Column of each slot, slot 0 in the low bits |
| ev_valid | output | 1 | An event is offered |
| ev_ready | input | 1 | Consumer takes the event |
| ev_code | output | CODE_W (8) | Code of the event |
| ev_press | output | 1 | 1 for press, 0 for release |
| ev_sync | output | 1 | One-cycle end-of-picture pulse |
| held_count | output | CNT_W (4) | Number of keys in the stored set |

## Verification
The assertions watch, on every cycle, that a stalled event stays frozen, that a release never follows a press within a picture, that sync stands alone and returns the block to idle, and that no event is offered while the input is ready. They also check that a ghosted picture leaves the count unchanged and that the count never exceeds the slot number. Only the bench's scenarios can show the event contents: the set difference that decides which keys are released, the function-key offset and the swallowing of the function key, the ghost decision on particular row and column patterns, and the flush on an empty picture.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REL  = 2'd1,
    ST_PRS  = 2'd2,
    ST_SYNC = 2'd3
  } seq_state_t;
endpackage

// File: rtl/kcr_slot_map.sv
// Converts per-slot row/column into codes, applies function-key handling.
module kcr_slot_map #(
  parameter int SLOTS     = 8,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 3,
  parameter int CODE_W    = 8,
  parameter int POSITIONS = 128,
  parameter int FN_CODE   = 120
) (
  input  logic [SLOTS-1:0]        mask,
  input  logic [SLOTS*ROW_W-1:0]  rows,
  input  logic [SLOTS*COL_W-1:0]  cols,
  input  logic                    fn_en,
  output logic [SLOTS*CODE_W-1:0] codes,
  output logic [SLOTS-1:0]        keep
);
  localparam int BASE_W = ROW_W + COL_W;

  logic [SLOTS-1:0] is_fn;
  logic             fn_seen;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [BASE_W-1:0] base;
    assign base     = {rows[s*ROW_W +: ROW_W], cols[s*COL_W +: COL_W]};
    assign is_fn[s] = mask[s] && (base == BASE_W'(FN_CODE));
    assign keep[s]  = mask[s] && !(fn_en && is_fn[s]);
    assign codes[s*CODE_W +: CODE_W] =
      fn_seen ? (CODE_W'(base) + CODE_W'(POSITIONS)) : CODE_W'(base);
  end

  assign fn_seen = fn_en && (|is_fn);
endmodule

// File: rtl/kcr_ghost_check.sv
// Flags pictures with a shared-row pair and a shared-column pair.
module kcr_ghost_check #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3
) (
  input  logic                   en,
  input  logic [SLOTS-1:0]       keep,
  input  logic [SLOTS*ROW_W-1:0] rows,
  input  logic [SLOTS*COL_W-1:0] cols,
  output logic                   ghost
);
  logic row_hit;
  logic col_hit;
  int   n_keys;

  always_comb begin
    row_hit = 1'b0;
    col_hit = 1'b0;
    n_keys  = $countones(keep);
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        if (keep[i] && keep[j]) begin
          if (rows[i*ROW_W +: ROW_W] == rows[j*ROW_W +: ROW_W]) row_hit = 1'b1;
          if (cols[i*COL_W +: COL_W] == cols[j*COL_W +: COL_W]) col_hit = 1'b1;
        end
      end
    end
    ghost = en && (n_keys >= 3) && row_hit && col_hit;
  end
endmodule

// File: rtl/kcr_event_seq.sv
// Holds the accepted key set and streams release, press and sync.
module kcr_event_seq
  import kcr_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic [SLOTS*CODE_W-1:0] in_codes,
  input  logic [SLOTS-1:0]        in_keep,
  input  logic                    ev_ready,
  output logic                    ev_valid,
  output logic [CODE_W-1:0]       ev_code,
  output logic                    ev_press,
  output logic                    ev_sync,
  output logic                    idle,
  output logic [CNT_W-1:0]        held_count
);
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  seq_state_t              state_q, state_d;
  logic [SLOTS*CODE_W-1:0] held_code_q, new_code_q;
  logic [SLOTS-1:0]        held_keep_q, new_keep_q;
  logic [SLOTS-1:0]        rel_q, rel_d, prs_q, prs_d;
  logic [CNT_W-1:0]        cnt_q;
  logic [SLOTS-1:0]        rel_calc, pend;
  logic [SEL_W-1:0]        sel;
  logic                    fire, ld_new, ld_held;

  // Stored keys missing from the incoming picture.
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      logic hit;
      hit = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        if (in_keep[j] && (in_codes[j*CODE_W +: CODE_W] == held_code_q[i*CODE_W +: CODE_W]))
          hit = 1'b1;
      end
      rel_calc[i] = held_keep_q[i] && !hit;
    end
  end

  // Lowest pending slot of the active group.
  always_comb begin
    pend = (state_q == ST_REL) ? rel_q : prs_q;
    sel  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend[i]) sel = SEL_W'(i);
    end
  end

  assign ev_valid = ((state_q == ST_REL) || (state_q == ST_PRS)) && (|pend);
  assign ev_press = (state_q == ST_PRS);
  assign ev_code  = (state_q == ST_REL) ? held_code_q[sel*CODE_W +: CODE_W]
                                        : new_code_q[sel*CODE_W +: CODE_W];
  assign ev_sync  = (state_q == ST_SYNC);
  assign idle     = (state_q == ST_IDLE);
  assign fire     = ev_valid && ev_ready;
  assign held_count = cnt_q;

  always_comb begin
    state_d = state_q;
    rel_d   = rel_q;
    prs_d   = prs_q;
    ld_new  = 1'b0;
    ld_held = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc) begin
          ld_new  = 1'b1;
          rel_d   = rel_calc;
          prs_d   = in_keep;
          state_d = ST_REL;
        end
      end
      ST_REL: begin
        if (rel_q == '0) state_d = ST_PRS;
        else if (fire)   rel_d[sel] = 1'b0;
      end
      ST_PRS: begin
        if (prs_q == '0) state_d = ST_SYNC;
        else if (fire)   prs_d[sel] = 1'b0;
      end
      ST_SYNC: begin
        ld_held = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rel_q       <= '0;
      prs_q       <= '0;
      new_code_q  <= '0;
      new_keep_q  <= '0;
      held_code_q <= '0;
      held_keep_q <= '0;
      cnt_q       <= '0;
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
      prs_q   <= prs_d;
      if (ld_new) begin
        new_code_q <= in_codes;
        new_keep_q <= in_keep;
      end
      if (ld_held) begin
        held_code_q <= new_code_q;
        held_keep_q <= new_keep_q;
        cnt_q       <= CNT_W'($countones(new_keep_q));
      end
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press));

  p_rel_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_press |=> !ev_valid || ev_press);

  p_sync_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |-> !ev_valid && !idle);

  p_sync_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> idle && !ev_sync);

  p_count_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    int'(held_count) <= SLOTS);
endmodule

// File: rtl/key_change_reporter.sv
module key_change_reporter #(
  parameter int SLOTS   = 8,
  parameter int ROWS    = 16,
  parameter int COLS    = 8,
  parameter int FN_CODE = 120
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       ghost_en,
  input  logic                                       fn_en,
  input  logic                                       snap_valid,
  output logic                                       snap_ready,
  input  logic [SLOTS-1:0]                           snap_mask,
  input  logic [SLOTS*$clog2(ROWS)-1:0]              snap_rows,
  input  logic [SLOTS*$clog2(COLS)-1:0]              snap_cols,
  output logic                                       ev_valid,
  input  logic                                       ev_ready,
  output logic [$clog2(2*ROWS*COLS)-1:0]             ev_code,
  output logic                                       ev_press,
  output logic                                       ev_sync,
  output logic [$clog2(SLOTS+1)-1:0]                 held_count
);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_W     = $clog2(COLS);
  localparam int POSITIONS = ROWS * COLS;
  localparam int CODE_W    = $clog2(2 * POSITIONS);
  localparam int CNT_W     = $clog2(SLOTS + 1);

  logic [SLOTS*CODE_W-1:0] codes;
  logic [SLOTS-1:0]        keep;
  logic                    ghost;
  logic                    idle;
  logic                    acc;

  kcr_slot_map #(
    .SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W),
    .POSITIONS(POSITIONS), .FN_CODE(FN_CODE)
  ) map_i (
    .mask(snap_mask), .rows(snap_rows), .cols(snap_cols), .fn_en(fn_en),
    .codes(codes), .keep(keep)
  );

  kcr_ghost_check #(
    .SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) ghost_i (
    .en(ghost_en), .keep(keep), .rows(snap_rows), .cols(snap_cols), .ghost(ghost)
  );

  assign snap_ready = idle;
  assign acc        = snap_valid && idle && !ghost;

  kcr_event_seq #(
    .SLOTS(SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .in_codes(codes), .in_keep(keep),
    .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_press(ev_press), .ev_sync(ev_sync), .idle(idle), .held_count(held_count)
  );

  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !snap_ready);

  p_ghost_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && snap_ready && ghost |=> snap_ready && $stable(held_count) && !ev_sync);
endmodule

// File: tb/key_change_reporter_tb_top.sv
`timescale 1ns/1ps
module key_change_reporter_tb_top;
  localparam int SLOTS = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ghost_en, fn_en, snap_valid, ev_ready;
  logic [SLOTS-1:0] s_mask;
  logic [SLOTS*4-1:0] s_rows;
  logic [SLOTS*3-1:0] s_cols;
  logic             snap_ready, ev_valid, ev_press, ev_sync;
  logic [7:0]       ev_code;
  logic [3:0]       held_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_c[32];
  int exp_p[32];
  int exp_n;
  int got_c[32];
  int got_p[32];
  int got_n;

  always #4 clk = ~clk;

  key_change_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .ghost_en(ghost_en), .fn_en(fn_en),
    .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_mask(s_mask),
    .snap_rows(s_rows), .snap_cols(s_cols), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_code(ev_code), .ev_press(ev_press),
    .ev_sync(ev_sync), .held_count(held_count)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sc(int r, int c);
    return r * 8 + c;
  endfunction

  task automatic clear_keys();
    s_mask = '0;
    s_rows = {SLOTS{4'hA}};
    s_cols = {SLOTS{3'h5}};
    exp_n  = 0;
  endtask

  task automatic set_key(int slot, int r, int c);
    s_mask[slot] = 1'b1;
    s_rows[slot*4 +: 4] = 4'(r);
    s_cols[slot*3 +: 3] = 3'(c);
  endtask

  task automatic want(int code, int press);
    exp_c[exp_n] = code;
    exp_p[exp_n] = press;
    exp_n++;
  endtask

  task automatic run_snapshot(string req, int exp_cnt, bit stall);
    bit synced = 0;
    int busy_bad = 0;
    @(negedge clk);
    chk(snap_ready == 1'b1, "R12", "snap_ready before picture", int'(snap_ready), 1);
    snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    got_n = 0;
    for (int cyc = 0; cyc < 200 && !synced; cyc++) begin
      automatic bit r = stall ? (cyc % 3 == 2) : 1'b1;
      ev_ready = r;
      if (ev_valid && snap_ready) busy_bad++;
      if (ev_valid && r && got_n < 32) begin
        got_c[got_n] = int'(ev_code);
        got_p[got_n] = int'(ev_press);
        got_n++;
      end
      if (ev_sync) synced = 1;
      @(negedge clk);
    end
    ev_ready = 1'b1;
    chk(synced, "R11", "sync seen", int'(synced), 1);
    chk(got_n == exp_n, req, "event count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(got_c[k] == exp_c[k], req, $sformatf("event %0d code", k), got_c[k], exp_c[k]);
      chk(got_p[k] == exp_p[k], req, $sformatf("event %0d press", k), got_p[k], exp_p[k]);
    end
    chk(busy_bad == 0, "R12", "events while ready", busy_bad, 0);
    chk(int'(held_count) == exp_cnt, "R13", "held_count", int'(held_count), exp_cnt);
    chk(snap_ready == 1'b1, "R12", "ready after sync", int'(snap_ready), 1);
  endtask

  task automatic run_dropped(string req, int exp_cnt);
    int seen = 0;
    @(negedge clk);
    snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    for (int cyc = 0; cyc < 6; cyc++) begin
      if (ev_valid || ev_sync || !snap_ready) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, "activity after ghost", seen, 0);
    chk(int'(held_count) == exp_cnt, req, "held_count after ghost", int'(held_count), exp_cnt);
  endtask

  // R1 reset state
  task automatic t_reset();
    chk(snap_ready == 1'b1, "R1", "snap_ready", int'(snap_ready), 1);
    chk(ev_valid == 1'b0, "R1", "ev_valid", int'(ev_valid), 0);
    chk(ev_sync == 1'b0, "R1", "ev_sync", int'(ev_sync), 0);
    chk(held_count == 4'd0, "R1", "held_count", int'(held_count), 0);
  endtask

  // R2 R4: first presses
  task automatic t_first();
    clear_keys(); set_key(0, 1, 2); set_key(1, 3, 5);
    want(sc(1, 2), 1); want(sc(3, 5), 1);
    run_snapshot("R2", 2, 0);
  endtask

  // R3 R5: release then presses
  task automatic t_change();
    clear_keys(); set_key(0, 3, 5); set_key(1, 5, 1);
    want(sc(1, 2), 0); want(sc(3, 5), 1); want(sc(5, 1), 1);
    run_snapshot("R3", 2, 0);
  endtask

  // R6: ghosted picture dropped
  task automatic t_ghost();
    ghost_en = 1'b1;
    clear_keys(); set_key(0, 2, 1); set_key(1, 2, 4); set_key(2, 6, 4);
    run_dropped("R6", 2);
  endtask

  // R7: same picture with filter off is accepted
  task automatic t_ghost_off();
    ghost_en = 1'b0;
    clear_keys(); set_key(0, 2, 1); set_key(1, 2, 4); set_key(2, 6, 4);
    want(sc(3, 5), 0); want(sc(5, 1), 0);
    want(sc(2, 1), 1); want(sc(2, 4), 1); want(sc(6, 4), 1);
    run_snapshot("R7", 3, 0);
  endtask

  // R7: filter on, shared row only
  task automatic t_row_only();
    ghost_en = 1'b1;
    clear_keys(); set_key(0, 0, 0); set_key(1, 0, 1); set_key(2, 3, 5);
    want(sc(2, 1), 0); want(sc(2, 4), 0); want(sc(6, 4), 0);
    want(sc(0, 0), 1); want(sc(0, 1), 1); want(sc(3, 5), 1);
    run_snapshot("R7", 3, 0);
  endtask

  // R8: function key held remaps and is swallowed
  task automatic t_fn_on();
    fn_en = 1'b1;
    clear_keys(); set_key(0, 15, 0); set_key(1, 2, 3);
    want(sc(0, 0), 0); want(sc(0, 1), 0); want(sc(3, 5), 0);
    want(sc(2, 3) + 128, 1);
    run_snapshot("R8", 1, 0);
  endtask

  // R8: function key released
  task automatic t_fn_off_key();
    clear_keys(); set_key(3, 2, 3);
    want(sc(2, 3) + 128, 0); want(sc(2, 3), 1);
    run_snapshot("R8", 1, 0);
  endtask

  // R8: mode off, function key ordinary
  task automatic t_fn_mode_off();
    fn_en = 1'b0;
    clear_keys(); set_key(5, 15, 0);
    want(sc(2, 3), 0); want(120, 1);
    run_snapshot("R8", 1, 0);
  endtask

  // R10: backpressure
  task automatic t_stall();
    clear_keys(); set_key(0, 4, 4); set_key(1, 7, 7); set_key(2, 9, 2);
    want(120, 0); want(sc(4, 4), 1); want(sc(7, 7), 1); want(sc(9, 2), 1);
    run_snapshot("R10", 3, 1);
  endtask

  // R9 R11: idle flush, then empty-on-empty
  task automatic t_flush();
    clear_keys();
    want(sc(4, 4), 0); want(sc(7, 7), 0); want(sc(9, 2), 0);
    run_snapshot("R9", 0, 0);
    clear_keys();
    run_snapshot("R11", 0, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; ghost_en = 1'b0; fn_en = 1'b0; snap_valid = 1'b0; ev_ready = 1'b1;
    clear_keys();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_change();
    t_ghost();
    t_ghost_off();
    t_row_only();
    t_fn_on();
    t_fn_off_key();
    t_fn_mode_off();
    t_stall();
    t_flush();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule